// File: doc/BRIEF.md
# Cable Presence Filter and Interrupt Unit

This block watches two asynchronous cable-status pins on a display transmitter: the hot-plug detect line and the receiver-sense line. Each pin is brought into the clock domain through a two-flop synchronizer. It then passes two filtering steps in series. The first is a short glitch filter, with a width of up to 15 clocks. The second is a long validation filter, whose width is programmed in units of 1024 clocks. Only after both steps does the filtered level of that pin change.

Each filtered level reports its rising and falling edges as sticky status bits. One external core interrupt input also feeds the status. A mask selects which sources drive the single registered interrupt line. Software works the block through a simple word-wide register port with combinational reads. Through that port it programs the filter widths, sets status bits by hand, acknowledges bits through a separate write-one-to-clear address, and reads the two filtered levels.

Top module: `cable_sense_irq`

## Requirements
- R1: After reset, every readable register reads 0 and `irq_o` is 0.
- R2: A steady change at a pin appears in the level register (address 4, bit 0 hot-plug, bit 1 receiver-sense) exactly 4 + N + M*1024 clock edges after it is driven, where N is the pin's glitch width and M its valid width. It is still at the old value one edge earlier.
- R3: A pin pulse lasting N cycles or fewer leaves the filtered level and the edge status bits unchanged. A pulse of N+1 cycles passes the glitch step.
- R4: A change that survives the glitch step but lasts M*1024 cycles or fewer is rejected. One that lasts M*1024+1 cycles changes the level.
- R5: Address 0 holds the filter setup and reads back as written. Bits 11:0 are the hot-plug valid width, bits 15:12 the hot-plug glitch width, bits 27:16 the receiver-sense valid width and bits 31:28 the receiver-sense glitch width.
- R6: A rising edge of the filtered hot-plug level sets status bit 1 and a falling edge sets bit 2. For receiver-sense the rising edge sets bit 6 and the falling edge sets bit 7. Each bit is set one clock after the level changes and stays set until cleared.
- R7: Status bit 0 is set in every cycle in which `core_irq_i` is high.
- R8: Writing address 2 sets each status bit whose data bit is 1, while 0 bits have no effect. Bits 3 to 5 and 8 to 30 always read 0.
- R9: Writing address 3 clears each status bit whose data bit is 1, while 0 bits have no effect. Address 3 reads 0.
- R10: When a hardware set and a clear reach the same status bit in the same cycle, the bit ends up set.
- R11: Address 1 bits 7:0 enable each status source (1 = enabled). `irq_o` goes high one clock after an enabled status bit is set, and falls one clock after the last enabled bit clears. Status read bit 31 equals `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hpd_pin_i | input | 1 | Asynchronous hot-plug detect pin |
| rxs_pin_i | input | 1 | Asynchronous receiver-sense pin |
| core_irq_i | input | 1 | Synchronous core interrupt request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A filter counter that is wrong by even one step shows up at the level register. The level changes one edge early or late against the 4 + N + M*1024 latency, or a pulse at exactly the threshold length is passed or rejected wrongly. This becomes visible within a few thousand cycles of the stimulus. A corrupted status or mask bit shows up on the status read at once and on `irq_o` one clock later. A wrong priority between set and clear shows up as a missing bit 0 on the first read after the colliding cycle.

// File: rtl/csi_pkg.sv
// Package: shared constants, register addresses and the filter setup layout
// for the cable presence filter and interrupt unit.
package csi_pkg;

    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 32;
    localparam int GLITCH_W   = 4;
    localparam int VALID_W    = 12;
    localparam int SCALE_LOG2 = 10;
    localparam int SRC_W      = 8;
    localparam int NUM_CH     = 2;

    // Register word addresses
    typedef enum logic [ADDR_W-1:0] {
        A_CFG  = 3'd0,
        A_MASK = 3'd1,
        A_STAT = 3'd2,
        A_CLR  = 3'd3,
        A_LVL  = 3'd4
    } reg_addr_e;

    // Status bit positions
    localparam int B_CORE     = 0;
    localparam int B_HPD_RISE = 1;
    localparam int B_HPD_FALL = 2;
    localparam int B_RXS_RISE = 6;
    localparam int B_RXS_FALL = 7;
    localparam int B_IRQ_RD   = 31;

    // Status bits that exist in hardware
    localparam logic [SRC_W-1:0] SRC_IMPL = 8'hC7;

    // Filter setup word, most significant field first
    typedef struct packed {
        logic [GLITCH_W-1:0] rxs_glitch;
        logic [VALID_W-1:0]  rxs_valid;
        logic [GLITCH_W-1:0] hpd_glitch;
        logic [VALID_W-1:0]  hpd_valid;
    } filt_cfg_t;

endpackage

// File: rtl/csi_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2; reset value of every flop is 0.
module csi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_q;

    // Shift the pin value through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/csi_hold_stage.sv
// Persistence stage: the output takes the input value only after the input
// has differed from it for limit_i+1 consecutive clocks. Any return to
// agreement restarts the count.
// Assumes: limit_i changes only while input and output agree.
module csi_hold_stage #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             q_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             q_q;

    // Count disagreement cycles and adopt the input once the limit is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q   <= 1'b0;
            cnt_q <= '0;
        end else if (d_i == q_q) begin
            cnt_q <= '0;
        end else if (cnt_q >= limit_i) begin
            q_q   <= d_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign q_o = q_q;

    // R3
    hold_takes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_q) |-> (q_q == $past(d_i)));

    // R4
    hold_waits_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_q) |-> ($past(cnt_q) >= $past(limit_i)));

endmodule

// File: rtl/csi_level_filter.sv
// One cable-status channel: synchronizer, short glitch stage, long
// validation stage (width scaled by 2**SCALE_LOG2), and edge pulses.
// Assumes: widths are reprogrammed only while the pin is steady.
module csi_level_filter #(
    parameter int GLITCH_W   = 4,
    parameter int VALID_W    = 12,
    parameter int SCALE_LOG2 = 10,
    parameter int SYNC_STG   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_i,
    input  logic [GLITCH_W-1:0] glitch_w_i,
    input  logic [VALID_W-1:0]  valid_w_i,
    output logic                level_o,
    output logic                rise_o,
    output logic                fall_o
);

    localparam int VCNT_W = VALID_W + SCALE_LOG2;

    logic              pin_s;
    logic              deglitched;
    logic              level;
    logic              level_d_q;
    logic [VCNT_W-1:0] valid_lim;

    assign valid_lim = {valid_w_i, {SCALE_LOG2{1'b0}}};

    csi_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    csi_hold_stage #(.CNT_W(GLITCH_W)) u_glitch (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (pin_s),
        .limit_i (glitch_w_i),
        .q_o     (deglitched)
    );

    csi_hold_stage #(.CNT_W(VCNT_W)) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (deglitched),
        .limit_i (valid_lim),
        .q_o     (level)
    );

    // Delay the filtered level by one clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) level_d_q <= 1'b0;
        else        level_d_q <= level;
    end

    assign level_o = level;
    assign rise_o  = level & ~level_d_q;
    assign fall_o  = ~level & level_d_q;

    // R6
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));

    // R6
    rise_tracks_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> ($past(level) == 1'b0));

endmodule

// File: rtl/csi_irq_regs.sv
// Register file and interrupt logic: filter setup, mask, sticky status
// (hardware set, software set, write-one-to-clear), level read-back,
// registered interrupt line.
// Assumes: set_evt_i is synchronous to clk; reads are combinational.
module csi_irq_regs
    import csi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NUM_CH-1:0] level_i,
    input  logic [SRC_W-1:0]  set_evt_i,
    output logic [DATA_W-1:0] reg_rdata,
    output filt_cfg_t         cfg_o,
    output logic              irq_o
);

    filt_cfg_t        cfg_q;
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] status_q;
    logic [SRC_W-1:0] status_d;
    logic [SRC_W-1:0] set_hw;
    logic [SRC_W-1:0] set_sw;
    logic [SRC_W-1:0] clr_sw;
    logic             irq_q;

    // Decode the write port into per-bit set and clear vectors
    always_comb begin
        set_hw = set_evt_i & SRC_IMPL;
        set_sw = (reg_we && reg_addr == A_STAT) ? (reg_wdata[SRC_W-1:0] & SRC_IMPL) : '0;
        clr_sw = (reg_we && reg_addr == A_CLR)  ? reg_wdata[SRC_W-1:0] : '0;
        status_d = (status_q & ~clr_sw) | set_hw | set_sw;
    end

    // Hold filter setup and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_CFG)  cfg_q  <= filt_cfg_t'(reg_wdata);
            if (reg_addr == A_MASK) mask_q <= reg_wdata[SRC_W-1:0];
        end
    end

    // Sticky status and registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_q    <= |(status_q & mask_q);
        end
    end

    // Combinational read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:   reg_rdata = cfg_q;
            A_MASK:  reg_rdata[SRC_W-1:0] = mask_q;
            A_STAT: begin
                reg_rdata[SRC_W-1:0] = status_q;
                reg_rdata[B_IRQ_RD]  = irq_q;
            end
            A_LVL:   reg_rdata[NUM_CH-1:0] = level_i;
            default: reg_rdata = '0;
        endcase
    end

    assign cfg_o = cfg_q;
    assign irq_o = irq_q;

    // R8
    always_comb begin
        if (rst_n) begin
            unimpl_zero_chk: assert ((status_q & ~SRC_IMPL) == '0);
        end
    end

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_hw) |=> ((status_q & $past(set_hw)) == $past(set_hw)));

    // R9
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CLR) |=>
            ((status_q & $past(reg_wdata[SRC_W-1:0]) & ~$past(set_hw)) == '0));

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(status_q & mask_q)));

    // R6
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == A_CLR) |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/cable_sense_irq.sv
// Top: two cable-status filter channels (hot-plug, receiver-sense) feeding
// the status/interrupt register block.
// Assumes: pins are asynchronous; core_irq_i and the register port are
// synchronous to clk.
module cable_sense_irq
    import csi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_pin_i,
    input  logic              rxs_pin_i,
    input  logic              core_irq_i,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);

    filt_cfg_t                        cfg;
    logic [NUM_CH-1:0]                pins;
    logic [NUM_CH-1:0][GLITCH_W-1:0]  glitch_w;
    logic [NUM_CH-1:0][VALID_W-1:0]   valid_w;
    logic [NUM_CH-1:0]                level;
    logic [NUM_CH-1:0]                rise;
    logic [NUM_CH-1:0]                fall;
    logic [SRC_W-1:0]                 set_evt;

    assign pins     = {rxs_pin_i, hpd_pin_i};
    assign glitch_w = {cfg.rxs_glitch, cfg.hpd_glitch};
    assign valid_w  = {cfg.rxs_valid, cfg.hpd_valid};

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            csi_level_filter #(
                .GLITCH_W   (GLITCH_W),
                .VALID_W    (VALID_W),
                .SCALE_LOG2 (SCALE_LOG2),
                .SYNC_STG   (2)
            ) u_filt (
                .clk        (clk),
                .rst_n      (rst_n),
                .pin_i      (pins[ch]),
                .glitch_w_i (glitch_w[ch]),
                .valid_w_i  (valid_w[ch]),
                .level_o    (level[ch]),
                .rise_o     (rise[ch]),
                .fall_o     (fall[ch])
            );
        end
    endgenerate

    // Route edge pulses and the core request onto their status bits
    always_comb begin
        set_evt             = '0;
        set_evt[B_CORE]     = core_irq_i;
        set_evt[B_HPD_RISE] = rise[0];
        set_evt[B_HPD_FALL] = fall[0];
        set_evt[B_RXS_RISE] = rise[1];
        set_evt[B_RXS_FALL] = fall[1];
    end

    csi_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .level_i   (level),
        .set_evt_i (set_evt),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg),
        .irq_o     (irq_o)
    );

endmodule

// File: tb/cable_sense_irq_bench.sv
`timescale 1ns/1ps
module cable_sense_irq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hpd = 1'b0;
    logic        rxs = 1'b0;
    logic        core = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cable_sense_irq u_cable_sense_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hpd_pin_i  (hpd),
        .rxs_pin_i  (rxs),
        .core_irq_i (core),
        .reg_we     (we),
        .reg_addr   (addr),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .irq_o      (irq)
    );

    function automatic logic [31:0] cfg_word(int hm, int hn, int rm, int rn);
        return {rn[3:0], rm[11:0], hn[3:0], hm[11:0]};
    endfunction

    function automatic bit pulse_passes(int len, int n, int m);
        int thr = (n > m * 1024) ? n : m * 1024;
        return len > thr;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Toggle a pin and measure the level change edge by edge (R2)
    task automatic latency(bit ch, int n, int m, string req);
        logic [31:0] v;
        logic        old_lvl;
        int          lat = 4 + n + m * 1024;
        wr(3'd3, 32'hFF);
        addr = 3'd4;
        old_lvl = ch ? rxs : hpd;
        if (ch) rxs = ~rxs; else hpd = ~hpd;
        for (int c = 1; c <= lat; c++) begin
            @(posedge clk);
            #1;
            v = rdata;
            if (c == lat - 1) check({req, " level before"}, {31'd0, v[ch]}, {31'd0, old_lvl});
            if (c == lat)     check({req, " level at"},     {31'd0, v[ch]}, {31'd0, ~old_lvl});
        end
        @(posedge clk);
        #1;
        rd(3'd2, v);
        check({req, " R6 edge status"}, v,
              32'd1 << (ch ? (old_lvl ? 7 : 6) : (old_lvl ? 2 : 1)));
    endtask

    task automatic pulse(bit ch, int len);
        @(negedge clk);
        if (ch) rxs = 1'b1; else hpd = 1'b1;
        repeat (len) @(negedge clk);
        if (ch) rxs = 1'b0; else hpd = 1'b0;
    endtask

    // Pulse a pin and compare the resulting status to the threshold rule
    task automatic pulse_trial(bit ch, int n, int m, int len, string req);
        logic [31:0] v;
        logic [31:0] exp;
        if (ch) wr(3'd0, cfg_word(0, 0, m, n));
        else    wr(3'd0, cfg_word(m, n, 0, 0));
        wr(3'd3, 32'hFF);
        pulse(ch, len);
        repeat (n + m * 1024 + 12) @(negedge clk);
        rd(3'd2, v);
        exp = pulse_passes(len, n, m) ? (ch ? 32'hC0 : 32'h06) : 32'h0;
        check(req, v, exp);
        rd(3'd4, v);
        check({req, " level back low"}, v, 32'd0);
    endtask

    initial begin
        #(5.0 * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], v);
            check("R1 reset read", v, 32'd0);
        end
        check("R1 irq reset", {31'd0, irq}, 32'd0);

        // R5: setup layout read-back
        wr(3'd0, 32'hA5A3_C7B1);
        rd(3'd0, v);
        check("R5 cfg readback", v, 32'hA5A3_C7B1);

        // R2: latencies on both channels and both directions
        wr(3'd0, cfg_word(0, 3, 0, 0));
        latency(1'b0, 3, 0, "R2 hpd rise");
        latency(1'b0, 3, 0, "R2 hpd fall");
        wr(3'd0, cfg_word(0, 0, 1, 2));
        latency(1'b1, 2, 1, "R2 rxs rise");
        latency(1'b1, 2, 1, "R2 rxs fall");
        wr(3'd0, cfg_word(0, 15, 0, 0));
        latency(1'b0, 15, 0, "R2 hpd max glitch");
        latency(1'b0, 15, 0, "R2 hpd max glitch fall");

        // R3: glitch threshold, exact boundary
        pulse_trial(1'b0, 5, 0, 5, "R3 pulse N rejected");
        pulse_trial(1'b0, 5, 0, 6, "R3 pulse N+1 accepted");
        pulse_trial(1'b1, 10, 0, 10, "R3 rxs pulse N rejected");
        pulse_trial(1'b1, 10, 0, 11, "R3 rxs pulse N+1 accepted");

        // R4: validation threshold, exact boundary
        pulse_trial(1'b0, 2, 1, 1024, "R4 pulse M*1024 rejected");
        pulse_trial(1'b0, 2, 1, 1025, "R4 pulse M*1024+1 accepted");
        pulse_trial(1'b1, 0, 1, 1024, "R4 rxs pulse rejected");

        // R3 R4 R6: random trials near the thresholds
        for (int t = 0; t < 30; t++) begin
            int  n   = $urandom_range(15, 0);
            int  m   = ($urandom_range(3, 0) == 0) ? 1 : 0;
            int  thr = (n > m * 1024) ? n : m * 1024;
            int  len = thr + $urandom_range(4, 0) - 2;
            bit  ch  = $urandom_range(1, 0) == 1;
            if (len < 1) len = 1;
            pulse_trial(ch, n, m, len, "R3 R4 R6 random pulse");
        end

        // R8: software set, unimplemented bits stay zero
        wr(3'd3, 32'hFF);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v);
        check("R8 sw set", v, 32'h0000_00C7);
        wr(3'd2, 32'h0);
        rd(3'd2, v);
        check("R8 zero write no effect", v, 32'h0000_00C7);

        // R9: selective clear
        wr(3'd3, 32'h0000_0042);
        rd(3'd2, v);
        check("R9 selective clear", v, 32'h0000_0085);
        rd(3'd3, v);
        check("R9 clear reads zero", v, 32'd0);
        wr(3'd3, 32'hFF);
        rd(3'd2, v);
        check("R9 clear all", v, 32'd0);

        // R7 R10: core request collides with clear, set wins
        @(negedge clk);
        core = 1'b1; we = 1'b1; addr = 3'd3; wdata = 32'h1;
        @(negedge clk);
        core = 1'b0; we = 1'b0;
        rd(3'd2, v);
        check("R10 set beats clear / R7 core", v, 32'h1);
        wr(3'd3, 32'h1);
        rd(3'd2, v);
        check("R7 core bit cleared", v, 32'd0);

        // R11: mask and registered interrupt
        wr(3'd1, 32'h40);
        rd(3'd1, v);
        check("R11 mask readback", v, 32'h40);
        wr(3'd2, 32'h01);
        @(negedge clk);
        check("R11 masked source no irq", {31'd0, irq}, 32'd0);
        wr(3'd2, 32'h40);
        check("R11 irq not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        check("R11 irq one cycle later", {31'd0, irq}, 32'd1);
        rd(3'd2, v);
        check("R11 bit31 mirrors irq", v, 32'h8000_0041);
        wr(3'd3, 32'h40);
        check("R11 irq holds one cycle", {31'd0, irq}, 32'd1);
        @(negedge clk);
        check("R11 irq falls", {31'd0, irq}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule